// File: doc/BRIEF.md
# Bitmap-to-Planar Tile Converter

This block turns rows of chunky pixels, one byte per pixel, into the bit-planar layout used by tile-based video hardware. Software writes eight pixel values into one of two pixel-register banks. Writing the last register of a bank starts a conversion when three controls agree: the transfer-enable control is on, tile conversion is selected, and automatic mode is off. The conversion then emits one plane byte per clock into a 2 KiB internal RAM.

The RAM address of each row is formed from an 11-bit destination base and a 4-bit row counter. That counter also picks which bank is converted, so successive rows alternate between the two banks. A bits-per-pixel format of 8, 4 or 2 sets how many plane bytes are written, how the base is aligned, and where the upper half of a tile lands.

Control is a two-state machine. In ST_IDLE the block accepts register writes. On transition GO (a qualifying write to a last register) it moves to ST_EMIT. In ST_EMIT it writes one plane per cycle. It stays there through transition STEP while planes remain, and returns to ST_IDLE through transition DONE after the last plane.

Top module: `bitplane_tiler`

## Requirements
- R1: After reset, busy and ram_we are low, the row counter is 0 and every pixel register holds 0.
- R2: A register write accepted in ST_IDLE stores reg_wdata into bank reg_addr[3] (0 = first bank) at pixel index reg_addr[2:0].
- R3: A conversion starts only when a write is accepted to pixel index 7 of either bank while cfg_dma_en=1, cfg_conv_sel=1 and cfg_auto=0. Any other write starts nothing.
- R4: cfg_fmt selects the plane count: 0 gives 8, 1 gives 4, and 2 or 3 gives 2. Each conversion makes exactly that many RAM writes.
- R5: Row-counter bit 0 picks the converted bank (0 = first, 1 = second), whichever bank's last register caused the start.
- R6: The row base is ((cfg_dest & ~(bpp*16-1)) + (row & 7)*2 + (row & 8)*bpp) mod 2048, taken at the start.
- R7: In plane byte i, bit 7-j equals bit i of pixel j, so pixel 0 lands in the MSB.
- R8: Plane i is written at row base + (i>>1)*16 + (i&1).
- R9: Each conversion increments the row counter modulo 16.
- R10: While cfg_dma_en is 0 the row counter is held at 0.
- R11: busy is high for exactly bpp cycles, beginning the cycle after the start edge. Register writes while busy are ignored and do not start a conversion.
- R12: Plane bytes go out on consecutive cycles in plane order 0..bpp-1, the first in the cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Pixel register write strobe |
| reg_addr | input | 4 | Bit 3 bank, bits 2:0 pixel index |
| reg_wdata | input | 8 | Pixel value |
| cfg_dma_en | input | 1 | Transfer enable; low clears the row counter |
| cfg_conv_sel | input | 1 | Tile conversion selected |
| cfg_auto | input | 1 | Automatic conversion mode (blocks manual start) |
| cfg_fmt | input | 2 | Colour depth format |
| cfg_dest | input | 11 | Destination base address in RAM |
| busy | output | 1 | Conversion in progress |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 11 | RAM write address |
| ram_wdata | output | 8 | Plane byte |

## Verification
Conversions are swept over all four format codes with more than sixteen rows each. This covers every row-counter value, the wrap back to zero, and both halves of the tile, so base-address and bank-selection errors show up separately from plane-order errors. Triggers alternate between the two banks' last registers while the counter alternates the converted bank, which separates a design that follows the written bank from one that follows the counter. Pixel patterns are scrambled arithmetically per row so that a swapped bit or pixel changes the expected byte. Separate cases use each blocked trigger condition, a non-last index, a disabled-then-enabled transfer, and a last-register write that lands mid-burst.

// File: rtl/tiler_pkg.sv
package tiler_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_EMIT} tiler_state_t;

    localparam int FMT_W = 2;
    localparam int BPP_W = 4;

    function automatic logic [BPP_W-1:0] fmt_to_bpp(input logic [FMT_W-1:0] fmt);
        case (fmt)
            2'd0:    return 4'd8;
            2'd1:    return 4'd4;
            default: return 4'd2;
        endcase
    endfunction
endpackage

// File: rtl/tiler_pixel_banks.sv
module tiler_pixel_banks #(
    parameter int PIX_W = 8,
    parameter int NPIX  = 8,
    localparam int RA_W  = $clog2(2*NPIX),
    localparam int IDX_W = $clog2(NPIX)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [RA_W-1:0]             wr_addr,
    input  logic [PIX_W-1:0]            wr_data,
    input  logic                        rd_bank,
    output logic [NPIX-1:0][PIX_W-1:0]  rd_pix
);
    logic [1:0][NPIX-1:0][PIX_W-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (wr_en) begin
            bank_q[wr_addr[RA_W-1]][wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    assign rd_pix = bank_q[rd_bank];
endmodule

// File: rtl/tiler_plane_gather.sv
module tiler_plane_gather #(
    parameter int PIX_W = 8,
    parameter int NPIX  = 8,
    localparam int PL_W = $clog2(PIX_W)
) (
    input  logic [NPIX-1:0][PIX_W-1:0] pix,
    input  logic [PL_W-1:0]            plane,
    output logic [NPIX-1:0]            plane_byte
);
    for (genvar j = 0; j < NPIX; j++) begin : g_px
        assign plane_byte[NPIX-1-j] = pix[j][plane];
    end
endmodule

// File: rtl/tiler_addr_gen.sv
module tiler_addr_gen #(
    parameter int NPIX   = 8,
    parameter int RAM_AW = 11,
    localparam int CNT_W  = $clog2(2*NPIX),
    localparam int STEP_W = $clog2(NPIX),
    localparam int BPP_W  = tiler_pkg::BPP_W
) (
    input  logic [RAM_AW-1:0] dest,
    input  logic [CNT_W-1:0]  row,
    input  logic [BPP_W-1:0]  bpp,
    output logic [RAM_AW-1:0] base
);
    logic [RAM_AW-1:0] bpp_x, span, keep_mask, step_off, half_off;

    always_comb begin
        bpp_x     = RAM_AW'(bpp);
        span      = bpp_x << CNT_W;
        keep_mask = ~(span - RAM_AW'(1));
        step_off  = RAM_AW'(row[STEP_W-1:0]) << 1;
        half_off  = row[STEP_W] ? (bpp_x << STEP_W) : '0;
        base      = (dest & keep_mask) + step_off + half_off;
    end
endmodule

// File: rtl/bitplane_tiler.sv
module bitplane_tiler #(
    parameter int PIX_W  = 8,
    parameter int NPIX   = 8,
    parameter int RAM_AW = 11,
    localparam int RA_W  = $clog2(2*NPIX)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [RA_W-1:0]       reg_addr,
    input  logic [PIX_W-1:0]      reg_wdata,
    input  logic                  cfg_dma_en,
    input  logic                  cfg_conv_sel,
    input  logic                  cfg_auto,
    input  logic [1:0]            cfg_fmt,
    input  logic [RAM_AW-1:0]     cfg_dest,
    output logic                  busy,
    output logic                  ram_we,
    output logic [RAM_AW-1:0]     ram_addr,
    output logic [NPIX-1:0]       ram_wdata
);
    import tiler_pkg::*;

    localparam int IDX_W = $clog2(NPIX);
    localparam int CNT_W = $clog2(2*NPIX);
    localparam int PL_W  = $clog2(PIX_W);

    tiler_state_t state, state_nx;

    logic [CNT_W-1:0]       row_cnt;
    logic [PL_W-1:0]        plane;
    logic [BPP_W-1:0]       run_bpp;
    logic [RAM_AW-1:0]      run_base;
    logic                   run_bank;
    logic                   accept, is_last, start, last_plane;
    logic [BPP_W-1:0]       cur_bpp;
    logic [RAM_AW-1:0]      base_now;
    logic [RAM_AW-1:0]      plane_off;
    logic [NPIX-1:0][PIX_W-1:0] sel_pix;
    logic [NPIX-1:0]        plane_byte;

    assign accept     = reg_we && (state == ST_IDLE);
    assign is_last    = (reg_addr[IDX_W-1:0] == IDX_W'(NPIX-1));
    assign start      = accept && is_last && cfg_dma_en && cfg_conv_sel && !cfg_auto;
    assign cur_bpp    = fmt_to_bpp(cfg_fmt);
    assign last_plane = (BPP_W'(plane) == run_bpp - BPP_W'(1));
    assign plane_off  = (RAM_AW'(plane >> 1) << CNT_W) | RAM_AW'(plane[0]);

    tiler_pixel_banks #(.PIX_W(PIX_W), .NPIX(NPIX)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .rd_bank (run_bank),
        .rd_pix  (sel_pix)
    );

    tiler_addr_gen #(.NPIX(NPIX), .RAM_AW(RAM_AW)) u_addr (
        .dest (cfg_dest),
        .row  (row_cnt),
        .bpp  (cur_bpp),
        .base (base_now)
    );

    tiler_plane_gather #(.PIX_W(PIX_W), .NPIX(NPIX)) u_gather (
        .pix        (sel_pix),
        .plane      (plane),
        .plane_byte (plane_byte)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: GO, STEP, DONE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)      state_nx = ST_EMIT;
            ST_EMIT: if (last_plane) state_nx = ST_IDLE;
        endcase
    end

    // Row counter and per-conversion context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_cnt  <= '0;
            plane    <= '0;
            run_bpp  <= BPP_W'(2);
            run_base <= '0;
            run_bank <= 1'b0;
        end else begin
            if (!cfg_dma_en)  row_cnt <= '0;
            else if (start)   row_cnt <= row_cnt + CNT_W'(1);

            if (start) begin
                plane    <= '0;
                run_bpp  <= cur_bpp;
                run_base <= base_now;
                run_bank <= row_cnt[0];
            end else if (state == ST_EMIT) begin
                plane    <= plane + PL_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state == ST_EMIT);
        ram_we    = (state == ST_EMIT);
        ram_addr  = run_base + plane_off;
        ram_wdata = plane_byte;
    end
endmodule

// File: rtl/tiler_checker.sv
module tiler_checker #(
    parameter int RAM_AW  = 11,
    parameter int IDX_W   = 3,
    parameter int GRP_LSB = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [IDX_W-1:0]  trig_idx,
    input logic              cfg_dma_en,
    input logic              cfg_conv_sel,
    input logic              cfg_auto,
    input logic              busy,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_addr
);
    logic [3:0] we_run, busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run   <= '0;
            busy_run <= '0;
        end else begin
            we_run   <= ram_we ? we_run + 4'd1 : 4'd0;
            busy_run <= busy   ? busy_run + 4'd1 : 4'd0;
        end
    end

    // R3
    a_r3_start_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && cfg_dma_en && cfg_conv_sel && !cfg_auto && trig_idx == '1));

    // R4
    a_r4_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_we) |-> (we_run == 4'd2 || we_run == 4'd4 || we_run == 4'd8));

    // R8
    a_r8_same_group: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> (ram_addr[RAM_AW-1:GRP_LSB] == $past(ram_addr[RAM_AW-1:GRP_LSB])));

    // R11
    a_r11_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < 4'd8));
endmodule

bind bitplane_tiler tiler_checker #(.RAM_AW(RAM_AW), .IDX_W(RA_W-1)) u_tiler_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .trig_idx     (reg_addr[RA_W-2:0]),
    .cfg_dma_en   (cfg_dma_en),
    .cfg_conv_sel (cfg_conv_sel),
    .cfg_auto     (cfg_auto),
    .busy         (busy),
    .ram_we       (ram_we),
    .ram_addr     (ram_addr)
);

// File: tb/bitplane_tiler_bench.sv
module bitplane_tiler_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic        cfg_dma_en, cfg_conv_sel, cfg_auto;
    logic [1:0]  cfg_fmt;
    logic [10:0] cfg_dest;
    logic        busy, ram_we;
    logic [10:0] ram_addr;
    logic [7:0]  ram_wdata;

    always #10 clk = ~clk;

    bitplane_tiler u_bitplane_tiler (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cfg_dma_en(cfg_dma_en), .cfg_conv_sel(cfg_conv_sel), .cfg_auto(cfg_auto),
        .cfg_fmt(cfg_fmt), .cfg_dest(cfg_dest),
        .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [7:0] pm [2][8];
    int cnt_m = 0;

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(int a, int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic int fmt_bpp(int f);
        return (f == 0) ? 8 : (f == 1) ? 4 : 2;
    endfunction

    function automatic int exp_base(int dest, int row, int bpp);
        int b;
        b = dest & ~(bpp*16 - 1);
        b = b + (row & 7)*2 + (row & 8)*bpp;
        return b & 'h7FF;
    endfunction

    function automatic int exp_plane(int bank, int p);
        int v = 0;
        for (int j = 0; j < 8; j++) if (pm[bank][j][p]) v |= (1 << (7-j));
        return v;
    endfunction

    function automatic int mix(int a);
        return ((a*73 + 29) ^ (a >> 3) ^ (a*5)) & 'hFF;
    endfunction

    // Trigger write, then check every plane byte of the burst.
    task automatic convert(int a, int d, bit intrude, string tag);
        int bpp, bank, base, ea;
        bpp  = fmt_bpp(int'(cfg_fmt));
        bank = cnt_m & 1;
        pm[a>>3][a&7] = 8'(d);
        base = exp_base(int'(cfg_dest), cnt_m, bpp);
        write_reg(a, d);
        for (int p = 0; p < bpp; p++) begin
            if (p > 0) @(negedge clk);
            ea = (base + (p>>1)*16 + (p&1)) & 'h7FF;
            check({tag, " R11 busy"}, int'(busy), 1);
            check({tag, " R12 we"}, int'(ram_we), 1);
            check({tag, " R6 R8 addr"}, int'(ram_addr), ea);
            check({tag, " R5 R7 data"}, int'(ram_wdata), exp_plane(bank, p));
            if (intrude && p == 1) begin
                reg_we = 1'b1; reg_addr = 4'(bank*8 + 7); reg_wdata = ~pm[bank][7];
            end else begin
                reg_we = 1'b0;
            end
        end
        @(negedge clk);
        reg_we = 1'b0;
        check({tag, " R4 end busy"}, int'(busy), 0);
        check({tag, " R4 end we"}, int'(ram_we), 0);
        cnt_m = (cnt_m + 1) & 15;
    endtask

    task automatic no_conv(int a, int d, string tag);
        pm[a>>3][a&7] = 8'(d);
        write_reg(a, d);
        for (int k = 0; k < 3; k++) begin
            if (k > 0) @(negedge clk);
            check({tag, " R3 no write"}, int'(ram_we), 0);
            check({tag, " R3 idle"}, int'(busy), 0);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    initial begin
        for (int b = 0; b < 2; b++) for (int j = 0; j < 8; j++) pm[b][j] = 8'h00;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        cfg_dma_en = 1'b1; cfg_conv_sel = 1'b1; cfg_auto = 1'b0;
        cfg_fmt = 2'd0; cfg_dest = 11'h3A5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 we", int'(ram_we), 0);
        // R1: counter 0, other pixels zero
        convert(7, 8'h81, 1'b0, "R1");

        // Sweep every format, wrapping the row counter (R4, R9, R5)
        for (int f = 0; f < 4; f++) begin
            @(negedge clk);
            cfg_fmt = 2'(f);
            for (int n = 0; n < 18; n++) begin
                cfg_dest = 11'((n*157 + f*901 + 13) & 'h7FF);
                for (int r = 0; r < 16; r++) begin
                    if (r != 7 && r != 15) begin
                        pm[r>>3][r&7] = 8'(mix(r + n*16 + f*300));
                        write_reg(r, mix(r + n*16 + f*300));
                    end
                end
                convert((n % 2) ? 15 : 7, mix(n*7 + f), 1'b0, "R4 R9 sweep");
            end
        end

        // R3: blocked trigger conditions
        @(negedge clk); cfg_fmt = 2'd1; cfg_auto = 1'b1;
        no_conv(7, 8'h5C, "auto");
        @(negedge clk); cfg_auto = 1'b0; cfg_conv_sel = 1'b0;
        no_conv(15, 8'hA7, "nosel");
        @(negedge clk); cfg_conv_sel = 1'b1;
        no_conv(4, 8'h3E, "midreg");
        no_conv(12, 8'hC1, "midreg");
        // R2: values stored by blocked writes show in the next conversion
        convert(7, 8'h96, 1'b0, "R2");
        convert(15, 8'h69, 1'b0, "R2");

        // R10: transfer disable clears the counter
        convert(7, 8'h12, 1'b0, "pre");
        @(negedge clk); cfg_dma_en = 1'b0;
        no_conv(15, 8'h77, "dis");
        cnt_m = 0;
        @(negedge clk); cfg_dma_en = 1'b1;
        convert(15, 8'hE4, 1'b0, "R10");

        // R11: last-register write during a burst is ignored
        @(negedge clk); cfg_fmt = 2'd0; cfg_dest = 11'h6F3;
        convert(7, 8'h2B, 1'b1, "R11 intrude");
        convert(15, 8'hD8, 1'b0, "R11 after");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule